// File: doc/BRIEF.md
# In-band Xon/Xoff flow controller

This block sits between a byte-wide serial receiver, the receive FIFO and the transmit serializer of a UART. It handles in-band software flow control using four programmable match characters: two "resume" characters (on_char_a, on_char_b) and two "stop" characters (off_char_a, off_char_b). A four-bit control field chooses, separately for each direction, whether flow control is off, uses only the A pair, uses only the B pair, or uses both characters in sequence. On the receive side, each incoming byte is either delivered to the FIFO one cycle later, or consumed as a flow-control character that pauses or resumes the local transmitter. On the transmit side, the block watches the receive FIFO fill level and requests a stop sequence or a resume sequence at programmable watermarks. These requests go to the serializer, which gives them priority over queued data.

A special-character mode is available when all four control bits are zero. In this mode, a received byte equal to off_char_b is delivered as normal data and also raises a sticky flag, which the host clears with a one-cycle pulse.

The receive path is a state machine with three states. RX_IDLE compares a new byte. In dual mode it moves to RX_HOLD when the byte is a first character. RX_HOLD either completes the pair and returns to RX_IDLE, or releases the held byte. After releasing, it stays in RX_HOLD when the new byte is itself a first character, and otherwise moves to RX_DRAIN. RX_DRAIN delivers the pending byte and returns to RX_IDLE. The transmit path also has three states. TX_IDLE moves to TX_FIRST when a watermark is crossed. TX_FIRST moves on when fc_ready is high: to TX_SECOND in dual mode, otherwise to TX_IDLE. TX_SECOND returns to TX_IDLE on fc_ready. Received bytes must be at least two cycles apart.

Top module: `swfc_ctrl`

## Requirements
- R1: After reset, out_valid, fc_valid, tx_pause and spec_flag are 0. With fc_ctrl = 0000, every received byte appears on out_data with out_valid one cycle after rx_valid, including bytes equal to any match character.
- R2: With fc_ctrl[1:0] = 10, a byte equal to off_char_a is not delivered and sets tx_pause, and a byte equal to on_char_a is not delivered and clears tx_pause. The change takes effect one cycle after the byte. All other bytes are delivered.
- R3: With fc_ctrl[1:0] = 01, R2 applies with off_char_b and on_char_b in place of the A characters. The A characters pass as data.
- R4: With fc_ctrl[1:0] = 11, off_char_a followed by off_char_b sets tx_pause, and on_char_a followed by on_char_b clears it. Neither byte of a completed pair is delivered, and tx_pause does not change on the first byte.
- R5: With fc_ctrl[1:0] = 11, when a held first character is followed by a byte that does not complete the pair, the held byte is delivered first. The new byte is then either held, if it is a first character, or delivered in the next cycle. Byte order is preserved.
- R6: While fc_ctrl[1:0] = 00, tx_pause is 0 from the next cycle on.
- R7: With spec_en = 1 and fc_ctrl = 0000, a byte equal to off_char_b is delivered and sets spec_flag together with out_valid. spec_flag stays set until a spec_clr pulse. When fc_ctrl is nonzero, spec_flag is not set.
- R8: fc_ctrl[3:2] selects the transmitted characters: 00 sends none, 10 sends the A character, 01 sends the B character, and 11 sends the A character and then the B character.
- R9: When rx_level >= level_hi and no stop sequence is outstanding, exactly one stop sequence is requested. When rx_level <= level_lo afterwards, exactly one resume sequence is requested.
- R10: While fc_valid is 1 and fc_ready is 0, fc_valid stays 1 and fc_data stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fc_ctrl | input | 4 | [3:2] transmit selection, [1:0] receive selection |
| spec_en | input | 1 | Special-character detect enable |
| on_char_a | input | DW | First resume character |
| on_char_b | input | DW | Second resume character |
| off_char_a | input | DW | First stop character |
| off_char_b | input | DW | Second stop character, also the special character |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | DW | Received byte, bit 0 is the LSB |
| spec_clr | input | 1 | One-cycle clear of spec_flag |
| rx_level | input | LW | Receive FIFO fill level |
| level_hi | input | LW | Stop watermark |
| level_lo | input | LW | Resume watermark |
| fc_ready | input | 1 | Serializer accepts fc_data |
| out_valid | output | 1 | Byte for the receive FIFO |
| out_data | output | DW | Delivered byte |
| tx_pause | output | 1 | Hold the transmitter after the current character |
| spec_flag | output | 1 | Special character seen (sticky) |
| fc_valid | output | 1 | Priority flow-control character request |
| fc_data | output | DW | Flow-control character to send |

## Verification
The bench builds the block with DW = 8 and LW = 5. This level width allows watermarks up to 31, so both the stop and the resume thresholds can be crossed, and crossed again, within a few cycles. With 8-bit characters, four distinct match values can be chosen, together with data bytes that match none of them. This covers every receive selection, broken pairs, back-to-back first characters, and the dual-character transmit sequence with a stalled fc_ready.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
    typedef enum logic [1:0] {
        FC_OFF    = 2'b00,
        FC_SECOND = 2'b01,
        FC_FIRST  = 2'b10,
        FC_BOTH   = 2'b11
    } fc_sel_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_HOLD,
        RX_DRAIN
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_FIRST,
        TX_SECOND
    } tx_state_t;
endpackage

// File: rtl/swfc_rx_match.sv
module swfc_rx_match
    import swfc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fc_sel_t       rx_sel,
    input  logic          spec_on,
    input  logic [DW-1:0] on_a,
    input  logic [DW-1:0] on_b,
    input  logic [DW-1:0] off_a,
    input  logic [DW-1:0] off_b,
    input  logic          in_valid,
    input  logic [DW-1:0] in_byte,
    output logic          out_valid,
    output logic [DW-1:0] out_byte,
    output logic          pause,
    output logic          spec_hit
);
    rx_state_t     state, nxt_state;
    logic [DW-1:0] held, nxt_held, pend, nxt_pend, nxt_byte;
    logic          held_off, nxt_held_off, nxt_valid, nxt_pause;

    always_comb begin
        nxt_state    = state;
        nxt_valid    = 1'b0;
        nxt_byte     = out_byte;
        nxt_pause    = (rx_sel == FC_OFF) ? 1'b0 : pause;
        nxt_held     = held;
        nxt_held_off = held_off;
        nxt_pend     = pend;
        spec_hit     = 1'b0;
        unique case (state)
            RX_IDLE: begin
                if (in_valid) begin
                    unique case (rx_sel)
                        FC_FIRST: begin
                            if (in_byte == off_a)     nxt_pause = 1'b1;
                            else if (in_byte == on_a) nxt_pause = 1'b0;
                            else begin
                                nxt_valid = 1'b1;
                                nxt_byte  = in_byte;
                            end
                        end
                        FC_SECOND: begin
                            if (in_byte == off_b)     nxt_pause = 1'b1;
                            else if (in_byte == on_b) nxt_pause = 1'b0;
                            else begin
                                nxt_valid = 1'b1;
                                nxt_byte  = in_byte;
                            end
                        end
                        FC_BOTH: begin
                            if (in_byte == off_a || in_byte == on_a) begin
                                nxt_held     = in_byte;
                                nxt_held_off = (in_byte == off_a);
                                nxt_state    = RX_HOLD;
                            end else begin
                                nxt_valid = 1'b1;
                                nxt_byte  = in_byte;
                            end
                        end
                        default: begin
                            nxt_valid = 1'b1;
                            nxt_byte  = in_byte;
                            spec_hit  = spec_on && (in_byte == off_b);
                        end
                    endcase
                end
            end
            RX_HOLD: begin
                if (in_valid) begin
                    if (in_byte == (held_off ? off_b : on_b)) begin
                        nxt_pause = held_off;
                        nxt_state = RX_IDLE;
                    end else begin
                        nxt_valid = 1'b1;
                        nxt_byte  = held;
                        if (in_byte == off_a || in_byte == on_a) begin
                            nxt_held     = in_byte;
                            nxt_held_off = (in_byte == off_a);
                        end else begin
                            nxt_pend  = in_byte;
                            nxt_state = RX_DRAIN;
                        end
                    end
                end
            end
            RX_DRAIN: begin
                nxt_valid = 1'b1;
                nxt_byte  = pend;
                nxt_state = RX_IDLE;
            end
            default: nxt_state = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
            pause     <= 1'b0;
            held      <= '0;
            held_off  <= 1'b0;
            pend      <= '0;
        end else begin
            out_valid <= nxt_valid;
            out_byte  <= nxt_byte;
            pause     <= nxt_pause;
            held      <= nxt_held;
            held_off  <= nxt_held_off;
            pend      <= nxt_pend;
        end
    end
endmodule

// File: rtl/swfc_tx_insert.sv
module swfc_tx_insert
    import swfc_pkg::*;
#(
    parameter int DW = 8,
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fc_sel_t       tx_sel,
    input  logic [DW-1:0] on_a,
    input  logic [DW-1:0] on_b,
    input  logic [DW-1:0] off_a,
    input  logic [DW-1:0] off_b,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] hi_mark,
    input  logic [LW-1:0] lo_mark,
    input  logic          ready,
    output logic          req_valid,
    output logic [DW-1:0] req_byte
);
    tx_state_t state, nxt_state;
    fc_sel_t   cur_sel, nxt_sel;
    logic      send_off, nxt_send_off, stop_out, nxt_stop_out;

    always_comb begin
        nxt_state    = state;
        nxt_sel      = cur_sel;
        nxt_send_off = send_off;
        nxt_stop_out = stop_out;
        unique case (state)
            TX_IDLE: begin
                if (tx_sel == FC_OFF) begin
                    nxt_stop_out = 1'b0;
                end else if (!stop_out && level >= hi_mark) begin
                    nxt_send_off = 1'b1;
                    nxt_stop_out = 1'b1;
                    nxt_sel      = tx_sel;
                    nxt_state    = TX_FIRST;
                end else if (stop_out && level <= lo_mark) begin
                    nxt_send_off = 1'b0;
                    nxt_stop_out = 1'b0;
                    nxt_sel      = tx_sel;
                    nxt_state    = TX_FIRST;
                end
            end
            TX_FIRST: begin
                if (ready) nxt_state = (cur_sel == FC_BOTH) ? TX_SECOND : TX_IDLE;
            end
            TX_SECOND: begin
                if (ready) nxt_state = TX_IDLE;
            end
            default: nxt_state = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= TX_IDLE;
            cur_sel  <= FC_OFF;
            send_off <= 1'b0;
            stop_out <= 1'b0;
        end else begin
            state    <= nxt_state;
            cur_sel  <= nxt_sel;
            send_off <= nxt_send_off;
            stop_out <= nxt_stop_out;
        end
    end

    always_comb begin
        req_valid = (state != TX_IDLE);
        unique case (state)
            TX_FIRST:  req_byte = (cur_sel == FC_SECOND) ? (send_off ? off_b : on_b)
                                                         : (send_off ? off_a : on_a);
            TX_SECOND: req_byte = send_off ? off_b : on_b;
            default:   req_byte = '0;
        endcase
    end
endmodule

// File: rtl/swfc_ctrl.sv
module swfc_ctrl
    import swfc_pkg::*;
#(
    parameter int DW = 8,
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    fc_ctrl,
    input  logic          spec_en,
    input  logic [DW-1:0] on_char_a,
    input  logic [DW-1:0] on_char_b,
    input  logic [DW-1:0] off_char_a,
    input  logic [DW-1:0] off_char_b,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          spec_clr,
    input  logic [LW-1:0] rx_level,
    input  logic [LW-1:0] level_hi,
    input  logic [LW-1:0] level_lo,
    input  logic          fc_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          tx_pause,
    output logic          spec_flag,
    output logic          fc_valid,
    output logic [DW-1:0] fc_data
);
    fc_sel_t rx_sel, tx_sel;
    logic    spec_on, spec_hit;

    assign rx_sel  = fc_sel_t'(fc_ctrl[1:0]);
    assign tx_sel  = fc_sel_t'(fc_ctrl[3:2]);
    assign spec_on = spec_en && (fc_ctrl == 4'b0000);

    swfc_rx_match #(.DW(DW)) i_rx (
        .clk(clk), .rst_n(rst_n), .rx_sel(rx_sel), .spec_on(spec_on),
        .on_a(on_char_a), .on_b(on_char_b), .off_a(off_char_a), .off_b(off_char_b),
        .in_valid(rx_valid), .in_byte(rx_data),
        .out_valid(out_valid), .out_byte(out_data), .pause(tx_pause), .spec_hit(spec_hit)
    );

    swfc_tx_insert #(.DW(DW), .LW(LW)) i_tx (
        .clk(clk), .rst_n(rst_n), .tx_sel(tx_sel),
        .on_a(on_char_a), .on_b(on_char_b), .off_a(off_char_a), .off_b(off_char_b),
        .level(rx_level), .hi_mark(level_hi), .lo_mark(level_lo),
        .ready(fc_ready), .req_valid(fc_valid), .req_byte(fc_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        spec_flag <= 1'b0;
        else if (spec_hit) spec_flag <= 1'b1;
        else if (spec_clr) spec_flag <= 1'b0;
    end
endmodule

// File: rtl/swfc_ctrl_chk.sv
module swfc_ctrl_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    fc_ctrl,
    input logic          spec_clr,
    input logic [DW-1:0] on_char_a,
    input logic [DW-1:0] off_char_a,
    input logic          out_valid,
    input logic [DW-1:0] out_data,
    input logic          tx_pause,
    input logic          spec_flag,
    input logic          fc_valid,
    input logic          fc_ready,
    input logic [DW-1:0] fc_data
);
    // R10: a stalled request holds its character
    assert_fc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_valid && !fc_ready) |=> (fc_valid && $stable(fc_data)));

    // R6: receive selection off releases the pause
    assert_pause_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_ctrl[1:0] == 2'b00) |=> !tx_pause);

    // R7: the flag is sticky until cleared
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_flag && !spec_clr) |=> spec_flag);

    // R7: the flag rises only together with a delivered byte
    assert_flag_with_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spec_flag) |-> out_valid);

    // R2: A characters never reach the FIFO in single-A mode
    assert_no_ctrl_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fc_ctrl[1:0] == 2'b10 && $past(fc_ctrl[1:0]) == 2'b10)
        |-> (out_data != on_char_a && out_data != off_char_a));
endmodule

bind swfc_ctrl swfc_ctrl_chk #(.DW(DW)) i_chk (
    .clk(clk), .rst_n(rst_n), .fc_ctrl(fc_ctrl), .spec_clr(spec_clr),
    .on_char_a(on_char_a), .off_char_a(off_char_a),
    .out_valid(out_valid), .out_data(out_data), .tx_pause(tx_pause),
    .spec_flag(spec_flag), .fc_valid(fc_valid), .fc_ready(fc_ready), .fc_data(fc_data)
);

// File: tb/test_swfc_ctrl.sv
module test_swfc_ctrl;
    localparam int DW = 8;
    localparam int LW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    fc_ctrl = '0;
    logic          spec_en = 1'b0, spec_clr = 1'b0, rx_valid = 1'b0, fc_ready = 1'b1;
    logic [DW-1:0] on_char_a = 8'h11, on_char_b = 8'h51, off_char_a = 8'h13, off_char_b = 8'h53;
    logic [DW-1:0] rx_data = '0;
    logic [LW-1:0] rx_level = '0, level_hi = 5'd12, level_lo = 5'd4;
    logic          out_valid, tx_pause, spec_flag, fc_valid;
    logic [DW-1:0] out_data, fc_data;

    int checks = 0, errors = 0;
    string cur_req = "R1";
    logic [DW-1:0] rx_exp[$];
    logic [DW-1:0] fc_exp[$];

    always #5 clk = ~clk;

    swfc_ctrl #(.DW(DW), .LW(LW)) i_swfc_ctrl (
        .clk(clk), .rst_n(rst_n), .fc_ctrl(fc_ctrl), .spec_en(spec_en),
        .on_char_a(on_char_a), .on_char_b(on_char_b), .off_char_a(off_char_a), .off_char_b(off_char_b),
        .rx_valid(rx_valid), .rx_data(rx_data), .spec_clr(spec_clr),
        .rx_level(rx_level), .level_hi(level_hi), .level_lo(level_lo), .fc_ready(fc_ready),
        .out_valid(out_valid), .out_data(out_data), .tx_pause(tx_pause), .spec_flag(spec_flag),
        .fc_valid(fc_valid), .fc_data(fc_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitors
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (rx_exp.size() == 0) chk(1'b0, cur_req, int'(out_data), -1);
            else begin
                automatic logic [DW-1:0] e = rx_exp.pop_front();
                chk(out_data == e, cur_req, int'(out_data), int'(e));
            end
        end
        if (rst_n && fc_valid && fc_ready) begin
            if (fc_exp.size() == 0) chk(1'b0, cur_req, int'(fc_data), -1);
            else begin
                automatic logic [DW-1:0] e = fc_exp.pop_front();
                chk(fc_data == e, cur_req, int'(fc_data), int'(e));
            end
        end
    end

    task automatic send(input logic [DW-1:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pass(input logic [DW-1:0] b);
        rx_exp.push_back(b);
        send(b);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        wait_cyc(3);
        // R1: reset state
        chk(!out_valid && !fc_valid && !tx_pause && !spec_flag, "R1",
            {out_valid, fc_valid, tx_pause, spec_flag}, 0);
        rst_n = 1'b1;
        wait_cyc(2);
        // R1: transparent with all control bits clear
        pass(8'h11); pass(8'h13); pass(8'hA5);
        chk(tx_pause == 1'b0, "R1", tx_pause, 0);

        // R2: single A pair
        cur_req = "R2"; fc_ctrl = 4'b0010;
        send(8'h13);
        chk(tx_pause == 1'b1, "R2", tx_pause, 1);
        pass(8'h55); pass(8'h51);
        send(8'h11);
        chk(tx_pause == 1'b0, "R2", tx_pause, 0);

        // R3: single B pair
        cur_req = "R3"; fc_ctrl = 4'b0001;
        send(8'h53);
        chk(tx_pause == 1'b1, "R3", tx_pause, 1);
        pass(8'h13);
        send(8'h51);
        chk(tx_pause == 1'b0, "R3", tx_pause, 0);

        // R4: dual pair
        cur_req = "R4"; fc_ctrl = 4'b0011;
        send(8'h13);
        chk(tx_pause == 1'b0, "R4", tx_pause, 0);
        send(8'h53);
        chk(tx_pause == 1'b1, "R4", tx_pause, 1);
        send(8'h11); send(8'h51);
        chk(tx_pause == 1'b0, "R4", tx_pause, 0);

        // R5: broken pairs release the held byte in order
        cur_req = "R5";
        rx_exp.push_back(8'h13); send(8'h13);
        pass(8'h42);
        rx_exp.push_back(8'h11); send(8'h11);
        send(8'h13); send(8'h53);
        chk(tx_pause == 1'b1, "R5", tx_pause, 1);
        rx_exp.push_back(8'h11); send(8'h11);
        send(8'h11); send(8'h51);
        chk(tx_pause == 1'b0, "R5", tx_pause, 0);

        // R6: receive selection off clears pause
        cur_req = "R6";
        send(8'h13); send(8'h53);
        chk(tx_pause == 1'b1, "R6", tx_pause, 1);
        fc_ctrl = 4'b0000;
        wait_cyc(2);
        chk(tx_pause == 1'b0, "R6", tx_pause, 0);

        // R7: special character detect
        cur_req = "R7"; spec_en = 1'b1;
        pass(8'h53);
        chk(spec_flag == 1'b1, "R7", spec_flag, 1);
        pass(8'h42);
        chk(spec_flag == 1'b1, "R7", spec_flag, 1);
        spec_clr = 1'b1; wait_cyc(1); spec_clr = 1'b0; wait_cyc(1);
        chk(spec_flag == 1'b0, "R7", spec_flag, 0);
        fc_ctrl = 4'b0010;
        pass(8'h53);
        chk(spec_flag == 1'b0, "R7", spec_flag, 0);
        fc_ctrl = 4'b0000; spec_en = 1'b0;

        // R8: transmit off sends nothing
        cur_req = "R8";
        rx_level = 5'd20; wait_cyc(5); rx_level = 5'd0; wait_cyc(3);

        // R9: watermarks, A characters
        cur_req = "R9"; fc_ctrl = 4'b1000;
        fc_exp.push_back(8'h13); rx_level = 5'd12; wait_cyc(5);
        rx_level = 5'd13; wait_cyc(5);
        rx_level = 5'd5;  wait_cyc(5);
        fc_exp.push_back(8'h11); rx_level = 5'd4; wait_cyc(5);
        chk(fc_exp.size() == 0, "R9", fc_exp.size(), 0);

        // R8: B characters and dual sequence
        cur_req = "R8"; fc_ctrl = 4'b0100;
        fc_exp.push_back(8'h53); rx_level = 5'd12; wait_cyc(5);
        fc_exp.push_back(8'h51); rx_level = 5'd3;  wait_cyc(5);
        fc_ctrl = 4'b1100;
        fc_exp.push_back(8'h13); fc_exp.push_back(8'h53); rx_level = 5'd15; wait_cyc(6);
        fc_exp.push_back(8'h11); fc_exp.push_back(8'h51); rx_level = 5'd0;  wait_cyc(6);
        chk(fc_exp.size() == 0, "R8", fc_exp.size(), 0);

        // R10: stalled handshake
        cur_req = "R10"; fc_ctrl = 4'b1000; fc_ready = 1'b0;
        fc_exp.push_back(8'h13); rx_level = 5'd20; wait_cyc(2);
        chk(fc_valid && fc_data == 8'h13, "R10", fc_data, 8'h13);
        wait_cyc(3);
        chk(fc_valid && fc_data == 8'h13, "R10", fc_data, 8'h13);
        fc_ready = 1'b1; wait_cyc(3);
        fc_exp.push_back(8'h11); rx_level = 5'd0; wait_cyc(5);

        chk(rx_exp.size() == 0, "R5", rx_exp.size(), 0);
        chk(fc_exp.size() == 0, "R10", fc_exp.size(), 0);
        finish_run();
    end
endmodule